// File: doc/BRIEF.md
# Run-time configurable asynchronous serial transmitter

This block turns one parallel word into an asynchronous serial frame on a single output wire. The frame's settings are all chosen at run time: the word length (4 to 16 bits), the stop length (half a bit up to two bits), the bit order, parity (none, even or odd), and inversion of the whole line. A word is handed over with a valid/ready handshake. A tick input, pulsing at sixteen times the bit rate, paces the frame. A busy output shows that a frame is on the wire.

The configuration inputs are captured together with the word. The surrounding logic can therefore prepare the settings for the next word while the current frame is still being sent. Ready returns only after the last stop period has ended and the line has gone back to idle.

Top module: `frame_tx`

## Requirements
- R1: After reset the block is idle: `in_ready` is 1, `busy` is 0 and `tx_line` is at the idle level.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while idle. `busy` is 1 from the cycle after acceptance until the final stop period ends, and ready returns in that same cycle.
- R3: `cfg_len` codes 1 through 13 select 4 through 16 data bits, one more bit per code step. Codes 0, 14 and 15 select 8 data bits. Only the selected number of low-order bits of `in_data` are sent.
- R4: `cfg_stop` sets the stop period in ticks: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32.
- R5: With `cfg_msb_first` at 0 the data bits go out from bit 0 upward. With it at 1 they go out from the highest selected bit downward.
- R6: `cfg_parity` value 2 appends an even parity bit after the data bits, and value 3 appends an odd parity bit. Values 0 and 1 append no parity bit. Even parity makes the count of ones across the data and parity bits even; odd parity makes that count odd.
- R7: With `cfg_invert` at 1 every frame level is inverted: start, data, parity and stop. While idle, `tx_line` equals the live `cfg_invert` input.
- R8: The start bit, each data bit and the parity bit last 16 ticks each. Cycles without a tick do not advance the frame.
- R9: Every configuration input is captured when the word is accepted. Changing the inputs during a frame does not alter that frame.
- R10: Without inversion the start bit is 0 and the stop level is 1. The start bit is on the line from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Pulse at 16 times the bit rate |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can take a word |
| in_data | input | MAX_BITS | Word to send |
| cfg_len | input | 4 | Data-length code |
| cfg_stop | input | 2 | Stop-length code |
| cfg_msb_first | input | 1 | Send the most significant bit first |
| cfg_parity | input | 2 | Parity mode code |
| cfg_invert | input | 1 | Invert the whole line |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The bench sweeps all sixteen length codes, covering both the reserved codes that fall back to 8 bits and the 4- and 16-bit extremes.
- A design that mapped the codes wrong would send the wrong number of data bits, and the bench would see a start or stop level where a data bit is due.
- Fractional stop lengths and tick gaps of one, two and three cycles are mixed in. An off-by-one in the tick counter would shift every later edge of the frame.
- The configuration is scrambled right after each acceptance. A design that read the live inputs would change order, parity or polarity part-way through a frame.
- The reserved parity code is among the cases, and so are all-ones words in odd parity with inversion. A parity bit inserted where none is due, or a parity term with the wrong sense, shows up as a miscompare at the parity slot.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } phase_e;

    localparam int LEN_CODE_W  = 4;
    localparam int STOP_CODE_W = 2;
    localparam int PAR_CODE_W  = 2;
endpackage

// File: rtl/frame_tx_cfg.sv
module frame_tx_cfg
    import frame_tx_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int OVS      = 16,
    parameter int NW       = 5,
    parameter int TW       = 6
) (
    input  logic [LEN_CODE_W-1:0]  len_code,
    input  logic [STOP_CODE_W-1:0] stop_code,
    input  logic [PAR_CODE_W-1:0]  par_code,
    output logic [NW-1:0]          nbits,
    output logic [TW-1:0]          stop_ticks,
    output logic                   par_en,
    output logic                   par_odd
);
    localparam int HALF     = OVS / 2;
    localparam int MAX_CODE = MAX_BITS - 3;

    always_comb begin
        if (len_code != '0 && int'(len_code) <= MAX_CODE) begin
            nbits = NW'(len_code) + NW'(3);
        end else begin
            nbits = NW'(8);
        end
        stop_ticks = TW'(HALF) * (TW'(stop_code) + TW'(1));
        par_en     = par_code[1];
        par_odd    = par_code[0];
    end
endmodule

// File: rtl/frame_tx_parity.sv
module frame_tx_parity #(
    parameter int MAX_BITS = 16,
    parameter int NW       = 5
) (
    input  logic [MAX_BITS-1:0] data,
    input  logic [NW-1:0]       nbits,
    input  logic                odd,
    output logic                par
);
    logic [MAX_BITS-1:0] mask;

    for (genvar g = 0; g < MAX_BITS; g++) begin : g_mask
        assign mask[g] = (NW'(g) < nbits);
    end

    assign par = (^(data & mask)) ^ odd;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int OVS      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [MAX_BITS-1:0]    in_data,
    input  logic [LEN_CODE_W-1:0]  cfg_len,
    input  logic [STOP_CODE_W-1:0] cfg_stop,
    input  logic                   cfg_msb_first,
    input  logic [PAR_CODE_W-1:0]  cfg_parity,
    input  logic                   cfg_invert,
    output logic                   tx_line,
    output logic                   busy
);
    localparam int NW = $clog2(MAX_BITS + 1);
    localparam int TW = $clog2(2 * OVS + 1);
    localparam int IW = $clog2(MAX_BITS);

    typedef struct packed {
        phase_e              ph;
        logic [TW-1:0]       cnt;
        logic [NW-1:0]       bit_i;
        logic [MAX_BITS-1:0] data;
        logic [NW-1:0]       nbits;
        logic [TW-1:0]       stop_t;
        logic                msb;
        logic                par_en;
        logic                par;
        logic                inv;
    } state_t;

    state_t q, d;

    logic [NW-1:0] dec_nbits;
    logic [TW-1:0] dec_stop;
    logic          dec_par_en;
    logic          dec_par_odd;
    logic          par_bit;

    frame_tx_cfg #(
        .MAX_BITS(MAX_BITS), .OVS(OVS), .NW(NW), .TW(TW)
    ) u_cfg (
        .len_code  (cfg_len),
        .stop_code (cfg_stop),
        .par_code  (cfg_parity),
        .nbits     (dec_nbits),
        .stop_ticks(dec_stop),
        .par_en    (dec_par_en),
        .par_odd   (dec_par_odd)
    );

    frame_tx_parity #(
        .MAX_BITS(MAX_BITS), .NW(NW)
    ) u_par (
        .data (in_data),
        .nbits(dec_nbits),
        .odd  (dec_par_odd),
        .par  (par_bit)
    );

    logic [NW-1:0] sel_idx;
    logic          data_lvl;
    logic          bit_end;
    logic          stop_end;

    always_comb begin
        sel_idx  = q.msb ? (q.nbits - NW'(1) - q.bit_i) : q.bit_i;
        data_lvl = q.data[sel_idx[IW-1:0]];
        bit_end  = tick && (q.cnt == TW'(OVS - 1));
        stop_end = tick && (q.cnt == q.stop_t - TW'(1));
    end

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                if (in_valid) begin
                    d.ph     = PH_START;
                    d.cnt    = '0;
                    d.bit_i  = '0;
                    d.data   = in_data;
                    d.nbits  = dec_nbits;
                    d.stop_t = dec_stop;
                    d.msb    = cfg_msb_first;
                    d.par_en = dec_par_en;
                    d.par    = par_bit;
                    d.inv    = cfg_invert;
                end
            end
            PH_START: begin
                if (bit_end) begin
                    d.ph  = PH_DATA;
                    d.cnt = '0;
                end else if (tick) begin
                    d.cnt = q.cnt + TW'(1);
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    d.cnt = '0;
                    if (q.bit_i == q.nbits - NW'(1)) begin
                        d.ph = q.par_en ? PH_PAR : PH_STOP;
                    end else begin
                        d.bit_i = q.bit_i + NW'(1);
                    end
                end else if (tick) begin
                    d.cnt = q.cnt + TW'(1);
                end
            end
            PH_PAR: begin
                if (bit_end) begin
                    d.ph  = PH_STOP;
                    d.cnt = '0;
                end else if (tick) begin
                    d.cnt = q.cnt + TW'(1);
                end
            end
            PH_STOP: begin
                if (stop_end) begin
                    d.ph  = PH_IDLE;
                    d.cnt = '0;
                end else if (tick) begin
                    d.cnt = q.cnt + TW'(1);
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.ph)
            PH_IDLE:  tx_line = cfg_invert;
            PH_START: tx_line = q.inv;
            PH_DATA:  tx_line = data_lvl ^ q.inv;
            PH_PAR:   tx_line = q.par ^ q.inv;
            PH_STOP:  tx_line = ~q.inv;
            default:  tx_line = cfg_invert;
        endcase
        in_ready = (q.ph == PH_IDLE);
        busy     = (q.ph != PH_IDLE);
    end
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic cfg_invert,
    input logic tx_line,
    input logic busy
);
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready); // R2

    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready)); // R2

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_line == cfg_invert)); // R7

    AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (tx_line == $past(cfg_invert))); // R10

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (busy && $stable(tx_line))); // R8
endmodule

bind frame_tx frame_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cfg_invert(cfg_invert),
    .tx_line   (tx_line),
    .busy      (busy)
);

// File: tb/test_frame_tx.sv
module test_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic [3:0]  cfg_len = 4'd5;
    logic [1:0]  cfg_stop = 2'd1;
    logic        cfg_msb_first = 1'b0;
    logic [1:0]  cfg_parity = 2'd0;
    logic        cfg_invert = 1'b0;
    logic        tx_line;
    logic        busy;

    int nvec = 0;
    int nfail = 0;
    int tick_div = 1;
    int tcnt = 0;
    int cyc = 0;
    bit running = 1'b0;

    always #4 clk = ~clk;

    frame_tx i_frame_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
        .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
        .cfg_parity(cfg_parity), .cfg_invert(cfg_invert),
        .tx_line(tx_line), .busy(busy)
    );

    // tick pulse every tick_div cycles, driven away from the active edge
    always @(negedge clk) begin
        tick = ((tcnt % tick_div) == 0);
        tcnt++;
    end

    // reference model: a queue of line segments (level, duration in ticks, tag)
    int    m_lv[$];
    int    m_du[$];
    string m_tg[$];
    int    m_cnt = 0;
    bit    m_busy = 1'b0;

    function automatic void build_frame(logic [15:0] dw, logic [3:0] lc, logic [1:0] sc,
                                        logic msb, logic [1:0] pc, logic inv);
        int  n = (lc >= 1 && lc <= 13) ? int'(lc) + 3 : 8;
        bit  p = 1'b0;
        m_lv.push_back(int'(inv)); m_du.push_back(16); m_tg.push_back("R10");
        for (int i = 0; i < n; i++) begin
            bit b = msb ? dw[n-1-i] : dw[i];
            p ^= b;
            m_lv.push_back(int'(b ^ inv)); m_du.push_back(16); m_tg.push_back("R3/R5");
        end
        if (pc[1]) begin
            p ^= pc[0];
            m_lv.push_back(int'(p ^ inv)); m_du.push_back(16); m_tg.push_back("R6");
        end
        m_lv.push_back(int'(!inv)); m_du.push_back(8 * (int'(sc) + 1)); m_tg.push_back("R4/R8");
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lv.delete(); m_du.delete(); m_tg.delete();
            m_cnt = 0; m_busy = 1'b0;
        end else if (!m_busy) begin
            if (in_valid) begin
                build_frame(in_data, cfg_len, cfg_stop, cfg_msb_first, cfg_parity, cfg_invert);
                m_busy = 1'b1;
                m_cnt = 0;
            end
        end else if (tick) begin
            m_cnt++;
            if (m_cnt == m_du[0]) begin
                void'(m_lv.pop_front()); void'(m_du.pop_front()); void'(m_tg.pop_front());
                m_cnt = 0;
                if (m_lv.size() == 0) m_busy = 1'b0;
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare every cycle, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        cyc++;
        if (rst_n && running) begin
            check("R2 busy", busy, m_busy);
            check("R2 ready", in_ready, !m_busy);
            if (m_busy) check(m_tg[0], tx_line, m_lv[0][0]);
            else        check("R7 idle", tx_line, cfg_invert);
        end
    end

    task automatic send(logic [15:0] dw, logic [3:0] lc, logic [1:0] sc, logic msb,
                        logic [1:0] pc, logic inv, int div);
        @(negedge clk);
        tick_div = div;
        in_data = dw; cfg_len = lc; cfg_stop = sc; cfg_msb_first = msb;
        cfg_parity = pc; cfg_invert = inv; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        // R9: scramble every setting while the frame is on the line
        in_data = ~dw; cfg_len = ~lc; cfg_stop = ~sc; cfg_msb_first = ~msb;
        cfg_parity = ~pc; cfg_invert = ~inv;
        while (busy) @(negedge clk);
        @(negedge clk);
        cfg_invert = inv;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        check("R1 ready", in_ready, 1'b1);
        check("R1 busy", busy, 1'b0);
        check("R1 line", tx_line, cfg_invert);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        #2;
        check("R1 ready after release", in_ready, 1'b1);
        check("R1 busy after release", busy, 1'b0);
        // R3 sweep of every length code with varied stop, order, parity, inversion, R8 tick gaps
        for (int i = 0; i < 16; i++) begin
            send(16'hA5C3 ^ 16'(i * 16'h1357), 4'(i), 2'(i), i[0], 2'(i >> 1),
                 i[2], 1 + (i % 3));
        end
        // boundary words
        send(16'hFFFF, 4'd13, 2'd3, 1'b1, 2'd3, 1'b1, 1);  // R6 odd, 16 ones, inverted
        send(16'h0000, 4'd13, 2'd0, 1'b0, 2'd2, 1'b0, 2);  // R6 even on zeros
        send(16'h000F, 4'd1,  2'd2, 1'b1, 2'd1, 1'b0, 3);  // R6 reserved code, 4 bits
        send(16'h8001, 4'd13, 2'd2, 1'b1, 2'd2, 1'b1, 1);  // R5 MSB-first 16-bit
        send(16'h00B4, 4'd5,  2'd0, 1'b0, 2'd3, 1'b0, 1);  // R4 half stop
        repeat (5) @(negedge clk);
        finish_run();
    end

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end
endmodule